// File: doc/BRIEF.md
# Two-Region Block Erase Range Sequencer

This block takes an erase request, given as a start byte address and a byte length, and turns it into a series of single-block erase commands for a downstream erase engine. The storage it serves is split into two erase regions. The low region holds a few small blocks and the high region holds many large blocks. Both block sizes are a whole number of bus words, and every size in bytes scales with the bus width. Because the block size changes partway through the address space, a request is checked and walked against the block size of whichever region each address falls in.

A request is checked before any command is issued. It is refused when it runs past the end of the device, or when its start or its end does not sit on a block boundary of its region. A request that passes is issued one block at a time over a request/acknowledge handshake. The address steps by the block size of the current region and moves to the high region when it reaches the low region's end. The engine may flag a failed erase together with its acknowledge. In that case the sequence stops at once and reports a failure. Otherwise it reports completion after the last block.

The control is one state machine, and its states are:
- `ST_IDLE`: waits for a start pulse and latches the request.
- `ST_CHECK`: evaluates the latched request.
- `ST_ISSUE`: holds the erase command until it is acknowledged.
- `ST_ADVANCE`: gives the stepped address and remaining length one cycle to settle.
- `ST_DONE`, `ST_FAIL` and `ST_REJECT`: each lasts one cycle, produces its outcome pulse and returns to `ST_IDLE`.

The transitions are:
- IDLE→CHECK on start.
- CHECK→REJECT when the request is out of range or misaligned.
- CHECK→DONE when the length is zero.
- CHECK→ISSUE otherwise.
- ISSUE→ADVANCE on a clean acknowledge.
- ISSUE→FAIL on a flagged acknowledge.
- ADVANCE→DONE when nothing remains.
- ADVANCE→ISSUE otherwise.

The region block sizes must be powers of two, and the low region's total size must be a multiple of the high region's block size.

Top module: `erase_range_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, reject_o and erase_req_o are all low.
- R2: A request whose start plus length is greater than the device size (low region size plus high region size) produces a reject_o pulse two cycles after the start pulse, and issues no erase command.
- R3: A request with nonzero length whose start is not a multiple of its region's block size is rejected, and issues no command. The start counts as high region when it is at or above the low region's end.
- R4: A request with nonzero length whose end (start plus length) is not a multiple of the block size of the end's region is rejected, and issues no command. The end counts as high region when it is at or above the low region's end, including an end equal to the device size.
- R5: An in-range request of zero length produces done_o two cycles after the start pulse, with no erase command and no alignment check.
- R6: An accepted request issues exactly one command per block, in ascending address order. The first command goes to the start address. Each later address is the previous one plus the block size of the previous address's region, and the last block ends at the request's end.
- R7: erase_req_o stays high with a stable erase_addr_o until erase_ack_i is seen. It is low in the cycle after each acknowledge.
- R8: An acknowledge with erase_bad_i high ends the sequence. fail_o pulses in the next cycle and no further command is issued.
- R9: After the last block is acknowledged without error, done_o pulses.
- R10: Each start pulse taken while idle yields exactly one outcome. done_o, fail_o and reject_o are one-cycle pulses that are never high together, and busy_o is low in the cycle after the outcome.
- R11: A start pulse while busy_o is high is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| start_addr_i | input | ADDR_W | Request start byte address |
| start_len_i | input | ADDR_W | Request length in bytes |
| busy_o | output | 1 | High from the cycle after an accepted start until the outcome |
| done_o | output | 1 | Completion pulse |
| fail_o | output | 1 | Failure pulse |
| reject_o | output | 1 | Refusal pulse |
| erase_req_o | output | 1 | Block erase command valid |
| erase_addr_o | output | ADDR_W | Byte address of the block to erase |
| erase_ack_i | input | 1 | Engine acknowledge of the current command |
| erase_bad_i | input | 1 | Qualifies erase_ack_i: the erase failed |

## Verification
The bench builds the sequencer with a 4-byte bus and tiny regions: four 16-byte low blocks and three 64-byte high blocks, for a 256-byte device. With these sizes the whole request space can be swept in steps of 8 bytes, past the device end. This covers every low/high combination of start and end regions, ends exactly on the region boundary and the device end, and misalignments that only the larger block size exposes. A full-device request is also repeated with the failure injected at each of its seven blocks, and a few byte-odd and start-while-busy cases are added.

// File: rtl/ers_pkg.sv
package ers_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_ADVANCE,
        ST_DONE,
        ST_FAIL,
        ST_REJECT
    } seq_state_t;

endpackage

// File: rtl/ers_req_check.sv
module ers_req_check #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned LO_BLK  = 16384,
    parameter int unsigned LO_END  = 131072,
    parameter int unsigned HI_BLK  = 131072,
    parameter int unsigned DEV_END = 4194304
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] len_i,
    output logic              too_far_o,
    output logic              empty_o,
    output logic              start_bad_o,
    output logic              end_bad_o
);
    localparam logic [ADDR_W:0] DEV_E   = (ADDR_W+1)'(DEV_END);
    localparam logic [ADDR_W:0] LO_E    = (ADDR_W+1)'(LO_END);
    localparam logic [ADDR_W:0] LO_MASK = (ADDR_W+1)'(LO_BLK - 1);
    localparam logic [ADDR_W:0] HI_MASK = (ADDR_W+1)'(HI_BLK - 1);

    logic [ADDR_W:0] start_w;
    logic [ADDR_W:0] end_w;
    logic            start_hi;
    logic            end_hi;

    always_comb begin
        start_w   = {1'b0, addr_i};
        end_w     = start_w + {1'b0, len_i};
        start_hi  = (start_w >= LO_E);
        end_hi    = (end_w >= LO_E);
        too_far_o = (end_w > DEV_E);
        empty_o   = (len_i == '0);
        start_bad_o = start_hi ? ((start_w & HI_MASK) != '0)
                               : ((start_w & LO_MASK) != '0);
        end_bad_o   = end_hi   ? ((end_w & HI_MASK) != '0)
                               : ((end_w & LO_MASK) != '0);
    end
endmodule

// File: rtl/ers_walker.sv
module ers_walker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LO_BLK = 16384,
    parameter int unsigned LO_END = 131072,
    parameter int unsigned HI_BLK = 131072
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [ADDR_W-1:0] ld_len_i,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [ADDR_W-1:0] rem_o,
    output logic              in_hi_o,
    output logic              rem_zero_o
);
    localparam logic [ADDR_W-1:0] LO_B = ADDR_W'(LO_BLK);
    localparam logic [ADDR_W-1:0] HI_B = ADDR_W'(HI_BLK);
    localparam logic [ADDR_W-1:0] LO_E = ADDR_W'(LO_END);

    logic [ADDR_W-1:0] blk;
    logic [ADDR_W-1:0] next_addr;

    always_comb begin
        blk       = in_hi_o ? HI_B : LO_B;
        next_addr = cur_addr_o + blk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr_o <= '0;
            rem_o      <= '0;
            in_hi_o    <= 1'b0;
        end else if (load_i) begin
            cur_addr_o <= ld_addr_i;
            rem_o      <= ld_len_i;
            in_hi_o    <= (ld_addr_i >= LO_E);
        end else if (step_i) begin
            cur_addr_o <= next_addr;
            rem_o      <= rem_o - blk;
            if (!in_hi_o && next_addr == LO_E)
                in_hi_o <= 1'b1;
        end
    end

    assign rem_zero_o = (rem_o == '0);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (rem_o >= blk));

    // R6
    region_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hi_o && !load_i) |=> in_hi_o);
endmodule

// File: rtl/erase_range_seq.sv
module erase_range_seq
    import ers_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned BUS_BYTES   = 4,
    parameter int unsigned LO_BLK_WRDS = 4096,
    parameter int unsigned LO_NBLK     = 8,
    parameter int unsigned HI_BLK_WRDS = 32768,
    parameter int unsigned HI_NBLK     = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [ADDR_W-1:0] start_len_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic              reject_o,
    output logic              erase_req_o,
    output logic [ADDR_W-1:0] erase_addr_o,
    input  logic              erase_ack_i,
    input  logic              erase_bad_i
);
    localparam int unsigned LO_BLK  = BUS_BYTES * LO_BLK_WRDS;
    localparam int unsigned HI_BLK  = BUS_BYTES * HI_BLK_WRDS;
    localparam int unsigned LO_END  = LO_BLK * LO_NBLK;
    localparam int unsigned DEV_END = LO_END + HI_BLK * HI_NBLK;

    seq_state_t        state_q, state_d;
    logic              load, step;
    logic [ADDR_W-1:0] cur_addr, rem;
    logic              in_hi, rem_zero;
    logic              too_far, empty, start_bad, end_bad;

    ers_walker #(
        .ADDR_W(ADDR_W), .LO_BLK(LO_BLK), .LO_END(LO_END), .HI_BLK(HI_BLK)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .ld_addr_i(start_addr_i), .ld_len_i(start_len_i),
        .cur_addr_o(cur_addr), .rem_o(rem), .in_hi_o(in_hi),
        .rem_zero_o(rem_zero)
    );

    ers_req_check #(
        .ADDR_W(ADDR_W), .LO_BLK(LO_BLK), .LO_END(LO_END),
        .HI_BLK(HI_BLK), .DEV_END(DEV_END)
    ) u_chk (
        .addr_i(cur_addr), .len_i(rem), .too_far_o(too_far),
        .empty_o(empty), .start_bad_o(start_bad), .end_bad_o(end_bad)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and walker controls
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    load    = 1'b1;
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (too_far)                 state_d = ST_REJECT;
                else if (empty)              state_d = ST_DONE;
                else if (start_bad || end_bad) state_d = ST_REJECT;
                else                         state_d = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (erase_ack_i) begin
                    if (erase_bad_i) state_d = ST_FAIL;
                    else begin
                        step    = 1'b1;
                        state_d = ST_ADVANCE;
                    end
                end
            end
            ST_ADVANCE: state_d = rem_zero ? ST_DONE : ST_ISSUE;
            ST_DONE, ST_FAIL, ST_REJECT: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        done_o       = (state_q == ST_DONE);
        fail_o       = (state_q == ST_FAIL);
        reject_o     = (state_q == ST_REJECT);
        erase_req_o  = (state_q == ST_ISSUE);
        erase_addr_o = cur_addr;
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req_o && !erase_ack_i) |=> (erase_req_o && $stable(erase_addr_o)));

    // R7
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req_o && erase_ack_i) |=> !erase_req_o);

    // R8
    fail_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req_o && erase_ack_i && erase_bad_i) |=> (fail_o && !erase_req_o));

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, fail_o, reject_o}));

    // R10
    outcome_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o || reject_o) |=> !(done_o || fail_o || reject_o || busy_o));

    // R6
    cmd_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req_o |-> ((erase_addr_o & ADDR_W'(in_hi ? HI_BLK - 1 : LO_BLK - 1)) == '0));

    // R6
    cmd_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req_o |-> ({1'b0, erase_addr_o} < (ADDR_W+1)'(DEV_END)));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (state_q != ST_CHECK));
endmodule

// File: tb/tb_erase_range_seq.sv
module tb_erase_range_seq;
    localparam int AW  = 12;
    localparam int B0  = 16;
    localparam int B1  = 64;
    localparam int R0E = 64;
    localparam int DEV = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] start_addr_i = '0;
    logic [AW-1:0] start_len_i = '0;
    logic          busy_o, done_o, fail_o, reject_o, erase_req_o;
    logic [AW-1:0] erase_addr_o;
    logic          erase_ack_i = 1'b0;
    logic          erase_bad_i = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    erase_range_seq #(
        .ADDR_W(AW), .BUS_BYTES(4), .LO_BLK_WRDS(4), .LO_NBLK(4),
        .HI_BLK_WRDS(16), .HI_NBLK(3)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .start_addr_i(start_addr_i), .start_len_i(start_len_i),
        .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
        .reject_o(reject_o), .erase_req_o(erase_req_o),
        .erase_addr_o(erase_addr_o), .erase_ack_i(erase_ack_i),
        .erase_bad_i(erase_bad_i)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // outcome codes: 0 done, 1 fail, 2 reject
    task automatic run(input int a, input int l, input int fidx, input bit poke);
        int ea[64];
        int nexp = 0;
        int kind;
        int e = a + l;
        int ncmd = 0;
        int got = -1;
        int lat = 0;
        string rq;
        if (e > DEV) begin kind = 2; rq = "R2"; end
        else if (l == 0) begin kind = 0; rq = "R5"; end
        else if ((a % ((a >= R0E) ? B1 : B0)) != 0) begin kind = 2; rq = "R3"; end
        else if ((e % ((e >= R0E) ? B1 : B0)) != 0) begin kind = 2; rq = "R4"; end
        else begin
            for (int p = a; p < e; p += ((p < R0E) ? B0 : B1)) begin
                ea[nexp] = p;
                nexp++;
            end
            if (fidx >= 0 && fidx < nexp) begin kind = 1; rq = "R8"; end
            else begin kind = 0; rq = "R9"; end
        end

        @(negedge clk);
        start_i = 1'b1; start_addr_i = AW'(a); start_len_i = AW'(l);
        @(negedge clk);
        start_i = 1'b0;
        while (got < 0 && lat < 3000) begin
            if (done_o)        got = 0;
            else if (fail_o)   got = 1;
            else if (reject_o) got = 2;
            else if (erase_req_o) begin
                chk(ncmd < nexp && int'(erase_addr_o) == ea[ncmd % 64], "R6 cmd addr",
                    int'(erase_addr_o), ea[ncmd % 64]);
                if (poke && ncmd == 1) begin
                    start_i = 1'b1; start_addr_i = AW'(1); start_len_i = AW'(3);
                    @(negedge clk);
                    start_i = 1'b0;
                    lat++;
                end
                repeat ((ncmd + a / 8) % 3) begin @(negedge clk); lat++; end
                chk(erase_req_o == 1'b1, "R7 req held", erase_req_o, 1);
                erase_ack_i = 1'b1;
                erase_bad_i = (ncmd == fidx);
                @(negedge clk);
                lat++;
                erase_ack_i = 1'b0;
                erase_bad_i = 1'b0;
                chk(erase_req_o == 1'b0, "R7 req drop", erase_req_o, 0);
                ncmd++;
                continue;
            end
            if (got < 0) begin @(negedge clk); lat++; end
        end
        chk(got == kind, {rq, " outcome"}, got, kind);
        if (kind == 2 || (kind == 0 && nexp == 0))
            chk(lat == 1, {rq, " latency"}, lat, 1);
        chk(ncmd == ((kind == 1) ? fidx + 1 : nexp), {rq, " cmd count"}, ncmd,
            (kind == 1) ? fidx + 1 : nexp);
        @(negedge clk);
        chk(!done_o && !fail_o && !reject_o && !busy_o, "R10 single pulse",
            {done_o, fail_o, reject_o, busy_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !fail_o && !reject_o && !erase_req_o, "R1 reset",
            {busy_o, done_o, fail_o, reject_o, erase_req_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // byte-odd and boundary cases
        run(4, 12, -1, 1'b0);    // R3
        run(16, 50, -1, 1'b0);   // R4
        run(0, 64, -1, 1'b0);    // R4 end at region boundary, R6
        run(250, 7, -1, 1'b0);   // R2
        run(1, 0, -1, 1'b0);     // R5 no alignment check
        run(256, 0, -1, 1'b0);   // R5 at device end
        run(257, 0, -1, 1'b0);   // R2
        run(48, 80, -1, 1'b0);   // R6 crosses regions
        run(0, 256, -1, 1'b1);   // R11 start while busy
        for (int f = 0; f < 7; f++) run(0, 256, f, 1'b0);  // R8
        for (int a = 0; a <= 264; a += 8)
            for (int l = 0; l <= 264; l += 8)
                run(a, l, -1, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule